// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block decides which hardware thread a single-issue core fetches from. Only one thread runs at a time, and it keeps running until it reports an expensive stall, such as a miss in the last cache level. On that event the controller stores the resume address of the stalled thread and asks the pipeline to discard that thread's instructions. It then looks for another thread that is able to run. The chosen thread's address is handed to the fetch unit. Fetch is then held in a refill phase whose length equals the pipeline depth, because no instruction of the new thread can complete before the pipeline is full again.

A thread that stalled is parked until its miss-done notification arrives. A separate per-thread ready input lets the surrounding core exclude threads altogether. The next thread is chosen in round-robin order, starting after the thread that just stalled. If no thread is eligible, the controller waits with fetch off. The address store, the refill timer and the round-robin picker are separate submodules.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: While reset is held, `flush_o`, `fetch_en_o`, `refill_o` and `pc_load_o` are 0 and `active_o` reads NTHR-1. After release, the first selection searches from thread 0 upward. Each thread t starts with address BASE_PC + t*PC_STRIDE.
- R2: A `miss_i` seen while the active thread is running (fetch on, not refilling) makes `flush_o` 1 in the next cycle for exactly one cycle. `fetch_en_o` is 0 from that cycle until a new thread is loaded.
- R3: `miss_i` has no effect while the controller is flushing, selecting or refilling: it raises no flush and changes no thread.
- R4: At an accepted miss, `pc_cur_i` is stored as the stalled thread's resume address. The thread stays ineligible until a later `miss_done_i` bit for it arrives. A done bit arriving in the same cycle as that thread's miss is ignored.
- R5: Selection scans threads active+1, active+2, ... with wrap-around and ends with the stalled thread itself. It takes the first thread whose `ready_i` bit is 1 and which is not waiting on a miss.
- R6: If no thread is eligible, `fetch_en_o` and `pc_load_o` stay 0 and `active_o` is unchanged until one becomes eligible. Selection then happens one cycle after the enabling input.
- R7: On selection, `pc_load_o` is 1 for one cycle. In that same cycle `active_o` shows the new thread and `resume_pc_o` shows its stored address.
- R8: `refill_o` and `fetch_en_o` are 1 for exactly DEPTH cycles, starting with the `pc_load_o` cycle. After that, `fetch_en_o` stays 1 with `refill_o` 0 (running).
- R9: `active_o` changes only in a `pc_load_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_i | input | 1 | Costly stall of the active thread |
| pc_cur_i | input | PCW | Resume address of the active thread, valid with `miss_i` |
| ready_i | input | NTHR | Per-thread permission to run |
| miss_done_i | input | NTHR | Per-thread miss completion pulse |
| active_o | output | clog2(NTHR) | Thread that owns fetch |
| resume_pc_o | output | PCW | Stored address of the active thread |
| pc_load_o | output | 1 | Load `resume_pc_o` into fetch |
| flush_o | output | 1 | Discard in-flight instructions |
| fetch_en_o | output | 1 | Fetch allowed |
| refill_o | output | 1 | Pipeline refilling after a switch |

## Verification
The bench builds the block with four threads, a 16-bit address and a refill depth of 3. A short depth keeps each switch brief, so many switches fit in one run. Four threads allow the bench to park every other thread on a miss, which forces the wait-with-fetch-off case. The same setup also covers the wrap-around scan, the skipping of a thread held off by its ready bit, and the case where a thread re-selects itself with its saved address.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
  typedef enum logic [1:0] {
    CG_RUN   = 2'd0,
    CG_DRAIN = 2'd1,
    CG_PICK  = 2'd2,
    CG_FILL  = 2'd3
  } cg_state_e;
endpackage

// File: rtl/cgmt_rr_pick.sv
// Round-robin scan: first eligible thread after `after`, wrapping, `after` last.
module cgmt_rr_pick #(
  parameter int NTHR = 4,
  parameter int TW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [NTHR-1:0] eligible,
  input  logic [TW-1:0]   after,
  output logic            hit,
  output logic [TW-1:0]   pick
);
  logic [TW:0] sum;

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    sum  = '0;
    // scan from farthest to nearest so the nearest candidate is assigned last
    for (int k = NTHR; k >= 1; k--) begin
      sum = {1'b0, after} + (TW+1)'(k);
      if (sum >= (TW+1)'(NTHR)) sum = sum - (TW+1)'(NTHR);
      if (eligible[sum[TW-1:0]]) begin
        hit  = 1'b1;
        pick = sum[TW-1:0];
      end
    end
  end
endmodule

// File: rtl/cgmt_pc_bank.sv
// One resume-address register per thread, each with its own boot value.
module cgmt_pc_bank #(
  parameter int             NTHR      = 4,
  parameter int             PCW       = 32,
  parameter int             TW        = (NTHR > 1) ? $clog2(NTHR) : 1,
  parameter logic [PCW-1:0] BASE_PC   = 'h1000,
  parameter logic [PCW-1:0] PC_STRIDE = 'h100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [TW-1:0]  wr_thr,
  input  logic [PCW-1:0] wr_pc,
  input  logic [TW-1:0]  rd_thr,
  output logic [PCW-1:0] rd_pc
);
  logic [NTHR-1:0][PCW-1:0] slots;

  for (genvar t = 0; t < NTHR; t++) begin : g_slot
    localparam logic [PCW-1:0] BOOT = BASE_PC + PCW'(t) * PC_STRIDE;
    logic [PCW-1:0] q;
    logic           we;
    assign we = wr_en && (wr_thr == TW'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= BOOT;
      else if (we) q <= wr_pc;
    end
    assign slots[t] = q;
  end

  assign rd_pc = slots[rd_thr];
endmodule

// File: rtl/cgmt_refill_timer.sv
// Counts refill cycles; `last` marks the final one.
module cgmt_refill_timer #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ena,
  output logic last
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || ena;
    cnt_d  = start ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(DEPTH - 1));
endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl
  import cgmt_pkg::*;
#(
  parameter int             NTHR      = 4,
  parameter int             PCW       = 32,
  parameter int             DEPTH     = 4,
  parameter logic [PCW-1:0] BASE_PC   = 'h1000,
  parameter logic [PCW-1:0] PC_STRIDE = 'h100,
  localparam int            TW        = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            miss_i,
  input  logic [PCW-1:0]  pc_cur_i,
  input  logic [NTHR-1:0] ready_i,
  input  logic [NTHR-1:0] miss_done_i,
  output logic [TW-1:0]   active_o,
  output logic [PCW-1:0]  resume_pc_o,
  output logic            pc_load_o,
  output logic            flush_o,
  output logic            fetch_en_o,
  output logic            refill_o
);
  cg_state_e       state_q, state_d;
  logic [TW-1:0]   active_q, active_d;
  logic [NTHR-1:0] wait_q, wait_d;
  logic            load_q;
  logic            save, start, hit, tlast;
  logic [TW-1:0]   pick;
  logic [NTHR-1:0] eligible;

  assign eligible = ready_i & ~wait_q;

  cgmt_rr_pick #(.NTHR(NTHR), .TW(TW)) u_pick (
    .eligible (eligible),
    .after    (active_q),
    .hit      (hit),
    .pick     (pick)
  );

  cgmt_pc_bank #(
    .NTHR(NTHR), .PCW(PCW), .TW(TW), .BASE_PC(BASE_PC), .PC_STRIDE(PC_STRIDE)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (save),
    .wr_thr (active_q),
    .wr_pc  (pc_cur_i),
    .rd_thr (active_q),
    .rd_pc  (resume_pc_o)
  );

  cgmt_refill_timer #(.DEPTH(DEPTH)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ena   (state_q == CG_FILL),
    .last  (tlast)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    active_d = active_q;
    save     = 1'b0;
    start    = 1'b0;
    unique case (state_q)
      CG_RUN: begin
        if (miss_i) begin
          state_d = CG_DRAIN;
          save    = 1'b1;
        end
      end
      CG_DRAIN: state_d = CG_PICK;
      CG_PICK: begin
        if (hit) begin
          state_d  = CG_FILL;
          active_d = pick;
          start    = 1'b1;
        end
      end
      CG_FILL: begin
        if (tlast) state_d = CG_RUN;
      end
      default: state_d = CG_PICK;
    endcase
  end

  // parking mask: a new miss outranks a completion in the same cycle
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      wait_d[t] = (save && (active_q == TW'(t))) || (wait_q[t] && !miss_done_i[t]);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CG_PICK;
      wait_q  <= '0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      load_q  <= start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active_q <= TW'(NTHR - 1);
    else if (start) active_q <= active_d;
  end

  assign active_o   = active_q;
  assign pc_load_o  = load_q;
  assign flush_o    = (state_q == CG_DRAIN);
  assign refill_o   = (state_q == CG_FILL);
  assign fetch_en_o = (state_q == CG_RUN) || (state_q == CG_FILL);
endmodule

// File: rtl/cgmt_switch_chk.sv
module cgmt_switch_chk #(
  parameter int NTHR  = 4,
  parameter int DEPTH = 4,
  parameter int TW    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_i,
  input logic [TW-1:0] active_o,
  input logic          pc_load_o,
  input logic          flush_o,
  input logic          fetch_en_o,
  input logic          refill_o
);
  logic [31:0] rcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rcnt_q <= '0;
    else if (refill_o) rcnt_q <= rcnt_q + 32'd1;
    else               rcnt_q <= '0;
  end

  p_miss_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_o && !refill_o && miss_i) |=> flush_o);
  p_flush_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);
  p_flush_nofetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !fetch_en_o);
  p_fill_ignores_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_o && miss_i) |=> !flush_o);
  p_load_opens_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (refill_o && fetch_en_o && rcnt_q == 32'd0));
  p_fill_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_o |-> (rcnt_q < 32'(DEPTH)));
  p_fill_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refill_o) |-> (rcnt_q == 32'(DEPTH) && fetch_en_o));
  p_switch_at_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_o) |-> pc_load_o);
endmodule

bind cgmt_switch_ctrl cgmt_switch_chk #(.NTHR(NTHR), .DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_i     (miss_i),
  .active_o   (active_o),
  .pc_load_o  (pc_load_o),
  .flush_o    (flush_o),
  .fetch_en_o (fetch_en_o),
  .refill_o   (refill_o)
);

// File: tb/sim_cgmt_switch_ctrl.sv
module sim_cgmt_switch_ctrl;
  localparam int NTHR  = 4;
  localparam int PCW   = 16;
  localparam int DEPTH = 3;
  localparam int TW    = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            miss_i = 1'b0;
  logic [PCW-1:0]  pc_cur_i = '0;
  logic [NTHR-1:0] ready_i = '1;
  logic [NTHR-1:0] miss_done_i = '0;
  logic [TW-1:0]   active_o;
  logic [PCW-1:0]  resume_pc_o;
  logic            pc_load_o, flush_o, fetch_en_o, refill_o;

  int total = 0;
  int bad = 0;
  int exp_thr[$];
  int exp_pc[$];
  int fill_run = 0;

  always #2 clk = ~clk;

  cgmt_switch_ctrl #(
    .NTHR(NTHR), .PCW(PCW), .DEPTH(DEPTH),
    .BASE_PC(16'h1000), .PC_STRIDE(16'h0100)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .pc_cur_i(pc_cur_i),
    .ready_i(ready_i), .miss_done_i(miss_done_i), .active_o(active_o),
    .resume_pc_o(resume_pc_o), .pc_load_o(pc_load_o), .flush_o(flush_o),
    .fetch_en_o(fetch_en_o), .refill_o(refill_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_switch(input int thr, input int pc);
    exp_thr.push_back(thr);
    exp_pc.push_back(pc);
  endtask

  // monitor: scoreboard for loads, plus refill length
  always @(negedge clk) begin
    if (rst_n) begin
      if (pc_load_o) begin
        if (exp_thr.size() == 0) begin
          chk(1'b0, "R7", "unexpected load thread", int'(active_o), -1);
        end else begin
          int et, ep;
          et = exp_thr.pop_front();
          ep = exp_pc.pop_front();
          chk(int'(active_o) == et, "R5", "selected thread", int'(active_o), et);
          chk(int'(resume_pc_o) == ep, "R7", "resume address", int'(resume_pc_o), ep);
          chk(refill_o && fetch_en_o, "R8", "refill at load", int'(refill_o), 1);
        end
      end
      if (refill_o) fill_run++;
      else if (fill_run != 0) begin
        chk(fill_run == DEPTH, "R8", "refill length", fill_run, DEPTH);
        chk(fetch_en_o, "R8", "fetch after refill", int'(fetch_en_o), 1);
        fill_run = 0;
      end
    end
  end

  task automatic wait_run();
    do @(negedge clk); while (!(fetch_en_o && !refill_o));
  endtask

  task automatic miss_on(input int pc);
    wait_run();
    miss_i   = 1'b1;
    pc_cur_i = PCW'(pc);
    @(negedge clk);
    miss_i = 1'b0;
    chk(flush_o == 1'b1, "R2", "flush raised", int'(flush_o), 1);
    chk(fetch_en_o == 1'b0, "R2", "fetch off in flush", int'(fetch_en_o), 0);
    @(negedge clk);
    chk(flush_o == 1'b0, "R2", "flush single cycle", int'(flush_o), 0);
  endtask

  task automatic check_stall(input int n, input int act);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!fetch_en_o && !pc_load_o, "R6", "fetch held off", int'(fetch_en_o), 0);
      chk(int'(active_o) == act, "R6", "thread held", int'(active_o), act);
    end
  endtask

  task automatic pulse_done(input logic [NTHR-1:0] m);
    miss_done_i = m;
    @(negedge clk);
    miss_done_i = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    chk(!flush_o && !fetch_en_o, "R1", "flush/fetch in reset", int'(flush_o | fetch_en_o), 0);
    chk(!refill_o && !pc_load_o, "R1", "refill/load in reset", int'(refill_o | pc_load_o), 0);
    chk(int'(active_o) == NTHR - 1, "R1", "thread in reset", int'(active_o), NTHR - 1);
    expect_switch(0, 'h1000);   // R1: first selection is thread 0 at its boot address
    rst_n = 1'b1;

    // R4 R5: thread 0 stalls, thread 1 next with boot address
    expect_switch(1, 'h1100);
    miss_on('h1234);
    expect_switch(2, 'h1200);
    miss_on('h2222);

    // R6: thread 3 not ready, threads 0 and 1 waiting -> hold
    ready_i = 4'b0111;
    miss_on('h3333);
    check_stall(6, 2);
    expect_switch(1, 'h2222);   // R4: done releases thread 1 with saved address
    pulse_done(4'b0010);

    // R5: wrap past waiting thread 2 to thread 3
    wait_run();
    pulse_done(4'b0001);
    ready_i = 4'b1111;
    expect_switch(3, 'h1300);
    miss_on('h4444);

    // R5 wrap to thread 0, restored address
    expect_switch(0, 'h1234);
    miss_on('h5555);

    // R3: miss during refill is ignored
    do @(negedge clk); while (!refill_o);
    miss_i = 1'b1;
    @(negedge clk);
    miss_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!flush_o, "R3", "no flush from refill miss", int'(flush_o), 0);
      chk(int'(active_o) == 0, "R3", "thread kept", int'(active_o), 0);
    end

    // R5 R6: everyone waiting, then the stalled thread selects itself
    miss_on('h6666);
    check_stall(5, 0);
    expect_switch(0, 'h6666);
    pulse_done(4'b0001);

    // R4: completion in the same cycle as the miss is ignored
    wait_run();
    pulse_done(4'b0100);
    wait_run();
    expect_switch(2, 'h3333);
    miss_i      = 1'b1;
    pc_cur_i    = 16'h7777;
    miss_done_i = 4'b0001;
    @(negedge clk);
    miss_i      = 1'b0;
    miss_done_i = '0;
    chk(flush_o == 1'b1, "R2", "flush raised", int'(flush_o), 1);
    miss_on('h8888);
    check_stall(5, 2);          // R4: thread 0 still waiting
    expect_switch(3, 'h5555);
    pulse_done(4'b1000);
    wait_run();
    expect_switch(0, 'h7777);   // R4: a fresh done releases thread 0
    pulse_done(4'b0001);
    miss_on('h9999);
    wait_run();
    repeat (2) @(negedge clk);
    chk(exp_thr.size() == 0, "R7", "pending switches", exp_thr.size(), 0);
    finish_run();
  end
endmodule